// File: doc/BRIEF.md
# CSR Instruction Access Unit

This unit executes the control-and-status-register instructions of a 32-bit RISC-V core. It works on a small machine-level register set: a scratch word, the exception return address, the trap cause, the trap value and the trigger select. Each valid cycle brings an instruction word, the source register value and the hart's current privilege level. The unit decodes the word and checks the access. It then performs the read-modify-write. One clock later it presents the old register value for write-back, or it raises an illegal-instruction flag.

The three operations are write, set bits and clear bits. Each has a register-source form and a 5-bit immediate form. Set and clear leave the register untouched when their source field is zero, so they serve as pure reads. Addresses the unit does not hold read as zero and ignore writes. The return-address register reads with its low alignment bits cleared. The trigger-select register reads back inverted, which tells software that no trigger hardware exists.

Top module: `csr_access_unit`

## Requirements
- R1: When `validIn` is high and the opcode `instr[6:0]` is not 7'b1110011, or `instr[13:12]` is 2'b00, `illegal` is high in the next cycle, `wbEn` is low and no register changes.
- R2: A legal access raises `wbEn` in the next cycle, with `rdIdx` equal to `instr[11:7]` and `wbData` equal to the register's read value before the access.
- R3: With `instr[13:12]` = 2'b01 (write), the register takes the source operand, even when the source field is zero.
- R4: With `instr[13:12]` = 2'b10 (set), the new value is old OR source. With 2'b11 (clear), it is old AND NOT source. Both leave the register unchanged when `instr[19:15]` is zero.
- R5: When `instr[14]` is 1, the source operand is `instr[19:15]` zero-extended, and `rs1Val` is ignored.
- R6: An access with `instr[29:28]` greater than `privLevel` is illegal.
- R7: A write attempt (a write operation, or set/clear with a nonzero source field) to an address with `instr[31:30]` = 2'b11 is illegal. A pure read of such an address is legal.
- R8: An illegal access changes no register and gives no write-back.
- R9: When `instr[11:7]` is zero, `wbEn` stays low but the register update still happens.
- R10: The return-address register (0x341) reads with its low `ALIGN_BITS` bits cleared. Its stored bits are kept as written.
- R11: The trigger-select register (0x7A0) reads as the bitwise inverse of its stored value.
- R12: Any address other than 0x340, 0x341, 0x342, 0x343 and 0x7A0 reads as zero, and writes to it change nothing readable.
- R13: After reset, all stored registers are zero and `wbEn`, `illegal`, `rdIdx` and `wbData` are zero.
- R14: In the cycle after `validIn` is low, `wbEn` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| rs1Val | input | XLEN | Source register value |
| privLevel | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| rdIdx | output | 5 | Destination register index |
| wbData | output | XLEN | Old register value for write-back |
| wbEn | output | 1 | Write-back strobe |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The assertions check the cycle-level protocol on every cycle. Outputs pulse only after a valid cycle, illegal and write-back never occur together, write-back never targets x0, and a wrong opcode or insufficient privilege always gives the flag. The data behaviour needs the bench's scenarios: read-modify-write results, suppression of zero-source writes, the masked and inverted read views, and the absence of side effects from illegal or unimplemented accesses. The bench shows these by reading the registers back after each access.

// File: rtl/csrUnitPkg.sv
package csrUnitPkg;

  localparam logic [6:0] SYSTEM_OPCODE = 7'b1110011;

  localparam logic [11:0] ADDR_SCRATCH = 12'h340;
  localparam logic [11:0] ADDR_EPC     = 12'h341;
  localparam logic [11:0] ADDR_CAUSE   = 12'h342;
  localparam logic [11:0] ADDR_TVAL    = 12'h343;
  localparam logic [11:0] ADDR_TSELECT = 12'h7A0;

  localparam int NUM_REGS = 5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csrOp_e;

  typedef enum logic [2:0] {
    SEL_SCRATCH = 3'd0,
    SEL_EPC     = 3'd1,
    SEL_CAUSE   = 3'd2,
    SEL_TVAL    = 3'd3,
    SEL_TSELECT = 3'd4
  } regSel_e;

  typedef struct packed {
    logic    capture;
    logic    commit;
    logic    hit;
    regSel_e sel;
    csrOp_e  op;
  } csrStrobe_t;

  typedef struct packed {
    logic    hit;
    regSel_e sel;
  } addrMatch_t;

  function automatic addrMatch_t matchAddr(input logic [11:0] addr);
    addrMatch_t m;
    m.hit = 1'b1;
    m.sel = SEL_SCRATCH;
    case (addr)
      ADDR_SCRATCH: m.sel = SEL_SCRATCH;
      ADDR_EPC:     m.sel = SEL_EPC;
      ADDR_CAUSE:   m.sel = SEL_CAUSE;
      ADDR_TVAL:    m.sel = SEL_TVAL;
      ADDR_TSELECT: m.sel = SEL_TSELECT;
      default:      m.hit = 1'b0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/csrCtrl.sv
module csrCtrl
  import csrUnitPkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            validIn,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [1:0]      privLevel,
  output csrStrobe_t      strobe,
  output logic [XLEN-1:0] srcOperand,
  output logic [4:0]      rdIdx,
  output logic            wbEn,
  output logic            illegal
);
  localparam int UIMM_PAD = XLEN - 5;

  logic [6:0]  opcode;
  logic [4:0]  rdField;
  logic [2:0]  funct3;
  logic [4:0]  rs1Field;
  logic [11:0] csrAddr;
  logic        isSystem;
  logic        opValid;
  logic        wantWrite;
  logic        privOk;
  logic        readOnlyViolation;
  logic        legal;
  addrMatch_t  match;

  assign opcode   = instr[6:0];
  assign rdField  = instr[11:7];
  assign funct3   = instr[14:12];
  assign rs1Field = instr[19:15];
  assign csrAddr  = instr[31:20];

  assign isSystem          = (opcode == SYSTEM_OPCODE);
  assign opValid           = (funct3[1:0] != 2'b00);
  assign wantWrite         = (funct3[1:0] == 2'b01) || (rs1Field != 5'd0);
  assign privOk            = (csrAddr[9:8] <= privLevel);
  assign readOnlyViolation = (csrAddr[11:10] == 2'b11) && wantWrite;
  assign legal             = isSystem && opValid && privOk && !readOnlyViolation;
  assign match             = matchAddr(csrAddr);

  assign srcOperand = funct3[2] ? {{UIMM_PAD{1'b0}}, rs1Field} : rs1Val;

  always_comb begin
    strobe.capture = validIn && legal;
    strobe.commit  = validIn && legal && wantWrite;
    strobe.hit     = match.hit;
    strobe.sel     = match.sel;
    strobe.op      = csrOp_e'(funct3[1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx   <= 5'd0;
      wbEn    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      wbEn    <= validIn && legal && (rdField != 5'd0);
      illegal <= validIn && !legal;
      if (validIn && legal) rdIdx <= rdField;
    end
  end
endmodule

// File: rtl/csrDatapath.sv
module csrDatapath
  import csrUnitPkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ALIGN_BITS = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  csrStrobe_t      strobe,
  input  logic [XLEN-1:0] srcOperand,
  output logic [XLEN-1:0] wbData
);
  localparam logic [XLEN-1:0] LOW_ONES = (XLEN'(1) << ALIGN_BITS) - XLEN'(1);
  localparam logic [XLEN-1:0] EPC_MASK = ~LOW_ONES;

  logic [XLEN-1:0] viewArr [NUM_REGS];
  logic [XLEN-1:0] readValue;
  logic [XLEN-1:0] newValue;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [XLEN-1:0] stored;
    logic            wrHere;

    assign wrHere = strobe.commit && strobe.hit && (strobe.sel == regSel_e'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stored <= '0;
      else if (wrHere) stored <= newValue;
    end

    if (i == int'(SEL_EPC)) begin : g_masked
      assign viewArr[i] = stored & EPC_MASK;
    end else if (i == int'(SEL_TSELECT)) begin : g_inverted
      assign viewArr[i] = ~stored;
    end else begin : g_plain
      assign viewArr[i] = stored;
    end
  end

  assign readValue = strobe.hit ? viewArr[strobe.sel] : '0;

  always_comb begin
    case (strobe.op)
      OP_WRITE: newValue = srcOperand;
      OP_SET:   newValue = readValue | srcOperand;
      OP_CLEAR: newValue = readValue & ~srcOperand;
      default:  newValue = readValue;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wbData <= '0;
    else if (strobe.capture) wbData <= readValue;
  end
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csrUnitPkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ALIGN_BITS = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            validIn,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [1:0]      privLevel,
  output logic [4:0]      rdIdx,
  output logic [XLEN-1:0] wbData,
  output logic            wbEn,
  output logic            illegal
);
  csrStrobe_t      strobe;
  logic [XLEN-1:0] srcOperand;

  csrCtrl #(.XLEN(XLEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .instr(instr),
    .rs1Val(rs1Val), .privLevel(privLevel), .strobe(strobe),
    .srcOperand(srcOperand), .rdIdx(rdIdx), .wbEn(wbEn), .illegal(illegal)
  );

  csrDatapath #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcOperand(srcOperand), .wbData(wbData)
  );
endmodule

// File: rtl/csrUnitChecker.sv
module csrUnitChecker (
  input logic        clk,
  input logic        rstN,
  input logic        validIn,
  input logic [31:0] instr,
  input logic [1:0]  privLevel,
  input logic [4:0]  rdIdx,
  input logic        wbEn,
  input logic        illegal
);
  // R14
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> (!wbEn && !illegal));

  // R8
  no_wb_on_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !wbEn);

  // R9
  no_wb_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (rdIdx != 5'd0));

  // R1
  bad_opcode_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && instr[6:0] != 7'b1110011) |=> (illegal && !wbEn));

  // R6
  priv_violation_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && instr[6:0] == 7'b1110011 && instr[13:12] != 2'b00
     && instr[29:28] > privLevel) |=> illegal);
endmodule

bind csr_access_unit csrUnitChecker u_checker (
  .clk(clk), .rstN(rstN), .validIn(validIn), .instr(instr),
  .privLevel(privLevel), .rdIdx(rdIdx), .wbEn(wbEn), .illegal(illegal)
);

// File: tb/csr_access_unit_bench.sv
module csr_access_unit_bench;
  localparam int XLEN = 32;
  localparam logic [31:0] EPC_MASK = 32'hFFFF_FFFE;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            validIn = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] rs1Val = '0;
  logic [1:0]      privLevel = 2'd3;
  logic [4:0]      rdIdx;
  logic [XLEN-1:0] wbData;
  logic            wbEn;
  logic            illegal;

  int total = 0;
  int bad = 0;
  logic [31:0] model [5];

  always #10 clk = ~clk;

  csr_access_unit #(.XLEN(XLEN), .ALIGN_BITS(1)) u_csr_access_unit (
    .clk(clk), .rstN(rstN), .validIn(validIn), .instr(instr), .rs1Val(rs1Val),
    .privLevel(privLevel), .rdIdx(rdIdx), .wbData(wbData), .wbEn(wbEn), .illegal(illegal)
  );

  function automatic int slotOf(input logic [11:0] a);
    case (a)
      12'h340: return 0;
      12'h341: return 1;
      12'h342: return 2;
      12'h343: return 3;
      12'h7A0: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    case (slotOf(a))
      0: return model[0];
      1: return model[1] & EPC_MASK;
      2: return model[2];
      3: return model[3];
      4: return ~model[4];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one instruction, model it, check the outputs one cycle later.
  task automatic runInstr(input string tag, input logic [6:0] opc, input logic [11:0] addr,
                          input logic [4:0] rs1f, input logic [2:0] f3, input logic [4:0] rd,
                          input logic [1:0] priv, input logic [31:0] srcReg);
    logic        legal, doWrite;
    logic [31:0] src, oldV, newV;
    int          s;
    doWrite = (f3[1:0] == 2'b01) || (rs1f != 0);
    legal   = (opc == 7'b1110011) && (f3[1:0] != 2'b00) && (addr[9:8] <= priv)
              && !((addr[11:10] == 2'b11) && doWrite);
    src     = f3[2] ? {27'd0, rs1f} : srcReg;
    oldV    = modelRead(addr);
    case (f3[1:0])
      2'b01:   newV = src;
      2'b10:   newV = oldV | src;
      default: newV = oldV & ~src;
    endcase
    s = slotOf(addr);
    @(negedge clk);
    instr = {addr, rs1f, f3, rd, opc};
    rs1Val = srcReg;
    privLevel = priv;
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    if (legal && doWrite && s >= 0) model[s] = newV;
    check({tag, " illegal"}, {31'd0, illegal}, {31'd0, !legal});
    check({tag, " wbEn"}, {31'd0, wbEn}, {31'd0, legal && rd != 0});
    if (legal && rd != 0) begin
      check({tag, " rdIdx"}, {27'd0, rdIdx}, {27'd0, rd});
      check({tag, " data"}, wbData, oldV);
    end
  endtask

  task automatic readBack(input string tag, input logic [11:0] addr, input logic [31:0] exp);
    runInstr(tag, 7'b1110011, addr, 5'd0, 3'b010, 5'd1, 2'd3, 32'h0);
    check({tag, " readback"}, wbData, exp);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [11:0] addrList [9];
    void'($urandom(32'd2024));
    addrList = '{12'h340, 12'h341, 12'h342, 12'h343, 12'h7A0, 12'hC00, 12'h140, 12'h015, 12'hF11};
    for (int i = 0; i < 5; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 wbEn", {31'd0, wbEn}, 32'd0);
    check("R13 illegal", {31'd0, illegal}, 32'd0);
    check("R13 rdIdx", {27'd0, rdIdx}, 32'd0);
    check("R13 wbData", wbData, 32'd0);
    rstN = 1'b1;
    readBack("R13 scratch", 12'h340, 32'h0);
    readBack("R11 tselect reset", 12'h7A0, 32'hFFFF_FFFF);
    // R3 write and R2 old value
    runInstr("R3 write", 7'b1110011, 12'h340, 5'd7, 3'b001, 5'd3, 2'd3, 32'hDEAD_BEEF);
    readBack("R3 scratch", 12'h340, 32'hDEAD_BEEF);
    // R3 write with zero source field still writes
    runInstr("R3 zero src", 7'b1110011, 12'h342, 5'd0, 3'b001, 5'd4, 2'd3, 32'h1234_5678);
    readBack("R3 cause", 12'h342, 32'h1234_5678);
    // R4 set / clear
    runInstr("R4 set", 7'b1110011, 12'h343, 5'd2, 3'b010, 5'd5, 2'd3, 32'h0000_00F0);
    runInstr("R4 clear", 7'b1110011, 12'h343, 5'd2, 3'b011, 5'd5, 2'd3, 32'h0000_0030);
    readBack("R4 tval", 12'h343, 32'h0000_00C0);
    // R4 clear with zero source: no change
    runInstr("R4 nop clear", 7'b1110011, 12'h343, 5'd0, 3'b011, 5'd5, 2'd3, 32'hFFFF_FFFF);
    readBack("R4 tval kept", 12'h343, 32'h0000_00C0);
    // R5 immediate forms
    runInstr("R5 imm write", 7'b1110011, 12'h340, 5'd31, 3'b101, 5'd6, 2'd3, 32'hFFFF_0000);
    readBack("R5 scratch", 12'h340, 32'h0000_001F);
    runInstr("R5 imm clear", 7'b1110011, 12'h340, 5'd3, 3'b111, 5'd6, 2'd3, 32'hFFFF_FFFF);
    readBack("R5 scratch clr", 12'h340, 32'h0000_001C);
    // R10 masked return address
    runInstr("R10 epc write", 7'b1110011, 12'h341, 5'd1, 3'b001, 5'd0, 2'd3, 32'h8000_0003);
    readBack("R10 epc", 12'h341, 32'h8000_0002);
    // R11 inverted trigger select
    runInstr("R11 tsel write", 7'b1110011, 12'h7A0, 5'd1, 3'b001, 5'd2, 2'd3, 32'h0000_0005);
    readBack("R11 tsel", 12'h7A0, 32'hFFFF_FFFA);
    // R9 rd zero still writes
    runInstr("R9 rd0", 7'b1110011, 12'h340, 5'd1, 3'b001, 5'd0, 2'd3, 32'hCAFE_0001);
    readBack("R9 scratch", 12'h340, 32'hCAFE_0001);
    // R1 bad opcode and bad funct3
    runInstr("R1 opcode", 7'b0110011, 12'h340, 5'd1, 3'b001, 5'd1, 2'd3, 32'h1);
    runInstr("R1 funct3", 7'b1110011, 12'h340, 5'd1, 3'b100, 5'd1, 2'd3, 32'h1);
    readBack("R8 scratch kept", 12'h340, 32'hCAFE_0001);
    // R6 privilege too low
    runInstr("R6 user", 7'b1110011, 12'h340, 5'd1, 3'b001, 5'd1, 2'd0, 32'h77);
    runInstr("R6 super", 7'b1110011, 12'h342, 5'd1, 3'b010, 5'd1, 2'd1, 32'h77);
    readBack("R8 after priv", 12'h340, 32'hCAFE_0001);
    // R7 read-only
    runInstr("R7 ro write", 7'b1110011, 12'hF11, 5'd1, 3'b001, 5'd1, 2'd3, 32'h9);
    runInstr("R7 ro read", 7'b1110011, 12'hF11, 5'd0, 3'b010, 5'd1, 2'd3, 32'h9);
    // R12 unimplemented
    runInstr("R12 unimpl write", 7'b1110011, 12'h140, 5'd1, 3'b001, 5'd1, 2'd3, 32'hABCD);
    readBack("R12 unimpl read", 12'h140, 32'h0);
    // R14 idle
    @(negedge clk);
    check("R14 idle wbEn", {31'd0, wbEn}, 32'd0);
    check("R14 idle illegal", {31'd0, illegal}, 32'd0);
    // Random mix (R2)
    for (int n = 0; n < 400; n++) begin
      logic [1:0] pv;
      logic [6:0] opc;
      pv  = ($urandom % 3 == 0) ? 2'd3 : 2'($urandom % 4);
      opc = ($urandom % 16 == 0) ? 7'b0010011 : 7'b1110011;
      runInstr("R2 random", opc, addrList[$urandom % 9], 5'($urandom % 4 == 0 ? 0 : $urandom),
               3'($urandom), 5'($urandom), pv, $urandom);
    end
    for (int i = 0; i < 5; i++) begin
      logic [11:0] a;
      a = addrList[i];
      readBack("R2 final", a, modelRead(a));
    end
    finishRun();
  end
endmodule